// File: doc/BRIEF.md
# Synthesizer Divider Pair with Ternary Reference Select

This block holds the digital dividers of a PLL frequency synthesizer. A reference divider counts reference-clock ticks and fires a one-cycle pulse every N ticks. N is one of nine values, picked by two three-level select inputs. A second divider counts oscillator-path ticks and fires a pulse every `LO_RATIO` ticks, where `LO_RATIO` defaults to 2464. When the reference is matched to the select setting, both pulse streams run at the same rate. For example, 16.384 MHz / 32 and 1261.568 MHz / 2464 both give 512 kHz.

Both dividers run on one system clock. Each counts only in cycles where its tick-enable input is high, so the enables stand in for the reference and oscillator clock edges. An increment input raises the reference factor by one, which moves a harmonic spur out of band. A test output carries one of the two pulse streams, or stays low, as chosen by a four-level control-mode code.

Top module: `synth_div_pair`

## Requirements
- R1: With `sel_a_i` then `sel_b_i` given as low=2'b00, open=2'b01, high=2'b10, the reference factor is: low,low=48; low,open=36; low,high=33; open,low=64; open,open=65; open,high=63; high,low=49; high,open=35; high,high=32. Between consecutive `ref_pulse_o` pulses there are exactly that many `ref_en_i` ticks.
- R2: A select code of 2'b11 gives the same factor as open (2'b01).
- R3: While `plus_one_i` is high, the reference factor is the R1 value plus one (range 33 to 66).
- R4: Between consecutive `lo_pulse_o` pulses there are exactly `LO_RATIO` (2464) `lo_en_i` ticks.
- R5: Each pulse output is registered. It is high for exactly one cycle, in the cycle after the terminal tick, and it is never high unless its enable was high in the previous cycle.
- R6: The divide factor is sampled only at the terminal tick. A select or `plus_one_i` change in mid-period lets the current period finish at its old length, and the new factor governs the period that follows.
- R7: When `ctrl_mode_i` is 2'b01 (open), `test_o` equals `ref_pulse_o`.
- R8: When `ctrl_mode_i` is 2'b11 (mid-supply), `test_o` equals `lo_pulse_o`.
- R9: When `ctrl_mode_i` is 2'b00 (low) or 2'b10 (high), `test_o` is 0.
- R10: A cycle with `clr_i` high clears both counters and both pulses. The first tick after the clear produces a pulse on each divider.
- R11: While `rst_ni` is low, all outputs are 0. After release, the first tick of each divider produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous counter clear, active high |
| ref_en_i | input | 1 | Reference-clock tick enable |
| lo_en_i | input | 1 | Oscillator-path tick enable |
| sel_a_i | input | 2 | First three-level reference select |
| sel_b_i | input | 2 | Second three-level reference select |
| plus_one_i | input | 1 | Adds one to the reference factor |
| ctrl_mode_i | input | 2 | Control mode: 00 low, 01 open, 10 high, 11 mid-supply |
| ref_pulse_o | output | 1 | Reference divider pulse |
| lo_pulse_o | output | 1 | Oscillator-path divider pulse |
| test_o | output | 1 | Test monitor output |

## Verification
The bench changes the selects, the increment input and the control mode at random points inside a period, so many periods straddle a factor change. If a design reloaded its count at once instead of at the terminal tick, the bench would measure a truncated interval, or an interval with the new factor one period too early.

A sweep applies every select pair, including the spare 2'b11 code, both with and without the increment. A wrong table entry, or 2'b11 decoded as high or low, would show up as a wrong tick count between pulses.

The tick enables are random. A design that counted clock cycles instead of ticks, or that held a pulse for two cycles, would show up as a wrong interval or as a pulse with no tick before it. Clears are applied in mid-count, and the bench requires a pulse on the very next tick.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_OPEN = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_ALT  = 2'b11
  } level_e;

  typedef enum logic [1:0] {
    CM_LOW  = 2'b00,
    CM_OPEN = 2'b01,
    CM_HIGH = 2'b10,
    CM_MID  = 2'b11
  } ctrl_mode_e;

  localparam int unsigned REF_MAX = 66;
  localparam int unsigned REF_W   = $clog2(REF_MAX + 1);

  // spare code folds onto open
  function automatic logic [1:0] fold_level(input logic [1:0] code);
    return (code == LVL_ALT) ? LVL_OPEN : code;
  endfunction

endpackage

// File: rtl/ref_factor_decode.sv
module ref_factor_decode
  import synth_div_pkg::*;
(
  input  logic [1:0]       sel_a_i,
  input  logic [1:0]       sel_b_i,
  input  logic             plus_one_i,
  output logic [REF_W-1:0] factor_o
);

  logic [1:0]       lvl_a, lvl_b;
  logic [REF_W-1:0] base;

  assign lvl_a = fold_level(sel_a_i);
  assign lvl_b = fold_level(sel_b_i);

  always_comb begin
    unique case ({lvl_a, lvl_b})
      {LVL_LOW,  LVL_LOW }: base = REF_W'(48);
      {LVL_LOW,  LVL_OPEN}: base = REF_W'(36);
      {LVL_LOW,  LVL_HIGH}: base = REF_W'(33);
      {LVL_OPEN, LVL_LOW }: base = REF_W'(64);
      {LVL_OPEN, LVL_OPEN}: base = REF_W'(65);
      {LVL_OPEN, LVL_HIGH}: base = REF_W'(63);
      {LVL_HIGH, LVL_LOW }: base = REF_W'(49);
      {LVL_HIGH, LVL_OPEN}: base = REF_W'(35);
      {LVL_HIGH, LVL_HIGH}: base = REF_W'(32);
      default:              base = REF_W'(65);
    endcase
  end

  assign factor_o = base + REF_W'(plus_one_i);

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] factor_i,
  output logic         pulse_o
);

  logic [W-1:0] cnt_q;
  logic         term;

  assign term = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= tick_i & term;
      if (tick_i) begin
        // factor sampled only at terminal count
        cnt_q <= term ? (factor_i - W'(1)) : (cnt_q - W'(1));
      end
    end
  end

endmodule

// File: rtl/test_mux.sv
module test_mux
  import synth_div_pkg::*;
(
  input  logic [1:0] ctrl_mode_i,
  input  logic       ref_pulse_i,
  input  logic       lo_pulse_i,
  output logic       test_o
);

  always_comb begin
    unique case (ctrl_mode_i)
      CM_OPEN: test_o = ref_pulse_i;
      CM_MID:  test_o = lo_pulse_i;
      default: test_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/synth_div_pair.sv
module synth_div_pair
  import synth_div_pkg::*;
#(
  parameter int unsigned LO_RATIO = 2464
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       ref_en_i,
  input  logic       lo_en_i,
  input  logic [1:0] sel_a_i,
  input  logic [1:0] sel_b_i,
  input  logic       plus_one_i,
  input  logic [1:0] ctrl_mode_i,
  output logic       ref_pulse_o,
  output logic       lo_pulse_o,
  output logic       test_o
);

  localparam int unsigned LO_W = $clog2(LO_RATIO + 1);

  logic [REF_W-1:0] ref_factor;

  ref_factor_decode u_decode (
    .sel_a_i    (sel_a_i),
    .sel_b_i    (sel_b_i),
    .plus_one_i (plus_one_i),
    .factor_o   (ref_factor)
  );

  tick_divider #(.W(REF_W)) u_ref_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .tick_i   (ref_en_i),
    .factor_i (ref_factor),
    .pulse_o  (ref_pulse_o)
  );

  tick_divider #(.W(LO_W)) u_lo_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .tick_i   (lo_en_i),
    .factor_i (LO_W'(LO_RATIO)),
    .pulse_o  (lo_pulse_o)
  );

  test_mux u_mux (
    .ctrl_mode_i (ctrl_mode_i),
    .ref_pulse_i (ref_pulse_o),
    .lo_pulse_i  (lo_pulse_o),
    .test_o      (test_o)
  );

endmodule

// File: rtl/synth_div_pair_chk.sv
module synth_div_pair_chk #(
  parameter int unsigned LO_RATIO = 2464
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clr_i,
  input logic       ref_en_i,
  input logic       lo_en_i,
  input logic [1:0] ctrl_mode_i,
  input logic       ref_pulse_o,
  input logic       lo_pulse_o,
  input logic       test_o
);

  logic [15:0] ref_cnt, lo_cnt;
  logic        ref_valid, lo_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_cnt <= '0; lo_cnt <= '0; ref_valid <= 1'b0; lo_valid <= 1'b0;
    end else if (clr_i) begin
      ref_cnt <= '0; lo_cnt <= '0; ref_valid <= 1'b0; lo_valid <= 1'b0;
    end else begin
      if (ref_pulse_o) begin
        ref_cnt   <= ref_en_i ? 16'd1 : 16'd0;
        ref_valid <= 1'b1;
      end else if (ref_en_i && ref_cnt != 16'hffff) begin
        ref_cnt <= ref_cnt + 16'd1;
      end
      if (lo_pulse_o) begin
        lo_cnt   <= lo_en_i ? 16'd1 : 16'd0;
        lo_valid <= 1'b1;
      end else if (lo_en_i && lo_cnt != 16'hffff) begin
        lo_cnt <= lo_cnt + 16'd1;
      end
    end
  end

  p_ref_period_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_pulse_o && ref_valid) |-> (ref_cnt >= 16'd32 && ref_cnt <= 16'd66));

  p_lo_period_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_pulse_o && lo_valid) |-> (lo_cnt == 16'(LO_RATIO)));

  p_ref_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |=> !ref_pulse_o);

  p_lo_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_pulse_o |=> !lo_pulse_o);

  p_ref_needs_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_pulse_o) |-> $past(ref_en_i));

  p_test_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_mode_i == 2'b01 && ref_pulse_o) |-> test_o);

  p_test_mid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_mode_i == 2'b11 && lo_pulse_o) |-> test_o);

  p_test_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_mode_i[0] == 1'b0) |-> !test_o);

  p_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!ref_pulse_o && !lo_pulse_o));

endmodule

bind synth_div_pair synth_div_pair_chk #(.LO_RATIO(LO_RATIO)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .ref_en_i    (ref_en_i),
  .lo_en_i     (lo_en_i),
  .ctrl_mode_i (ctrl_mode_i),
  .ref_pulse_o (ref_pulse_o),
  .lo_pulse_o  (lo_pulse_o),
  .test_o      (test_o)
);

// File: tb/synth_div_pair_tb_top.sv
module synth_div_pair_tb_top;

  localparam int LO_RATIO = 2464;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       ref_en_i = 1'b0;
  logic       lo_en_i = 1'b0;
  logic [1:0] sel_a_i = 2'b00;
  logic [1:0] sel_b_i = 2'b00;
  logic       plus_one_i = 1'b0;
  logic [1:0] ctrl_mode_i = 2'b00;
  logic       ref_pulse_o, lo_pulse_o, test_o;

  always #5 clk_i = ~clk_i;

  synth_div_pair #(.LO_RATIO(LO_RATIO)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .ref_en_i    (ref_en_i),
    .lo_en_i     (lo_en_i),
    .sel_a_i     (sel_a_i),
    .sel_b_i     (sel_b_i),
    .plus_one_i  (plus_one_i),
    .ctrl_mode_i (ctrl_mode_i),
    .ref_pulse_o (ref_pulse_o),
    .lo_pulse_o  (lo_pulse_o),
    .test_o      (test_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int ref_ticks = 0, ref_last = 0, ref_exp = 0;
  int lo_ticks  = 0, lo_last  = 0, lo_exp  = 0;
  bit ref_prev = 1'b0, lo_prev = 1'b0;
  bit ref_tick_prev = 1'b0, lo_tick_prev = 1'b0;

  function automatic int ref_model(input logic [1:0] a, input logic [1:0] b, input logic p);
    int base;
    logic [1:0] fa, fb;
    fa = (a == 2'b11) ? 2'b01 : a;
    fb = (b == 2'b11) ? 2'b01 : b;
    case ({fa, fb})
      4'b0000: base = 48;
      4'b0001: base = 36;
      4'b0010: base = 33;
      4'b0100: base = 64;
      4'b0101: base = 65;
      4'b0110: base = 63;
      4'b1000: base = 49;
      4'b1001: base = 35;
      default: base = 32;
    endcase
    return base + int'(p);
  endfunction

  function automatic logic test_model(input logic [1:0] m, input logic rp, input logic lp);
    if (m == 2'b01) return rp;
    if (m == 2'b11) return lp;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic sample();
    check(test_o == test_model(ctrl_mode_i, ref_pulse_o, lo_pulse_o),
          (ctrl_mode_i == 2'b01) ? "R7" : (ctrl_mode_i == 2'b11) ? "R8" : "R9",
          int'(test_o), int'(test_model(ctrl_mode_i, ref_pulse_o, lo_pulse_o)));
    if (ref_pulse_o) begin
      check(!ref_prev && ref_tick_prev, "R5 ref pulse shape", int'(ref_prev), 0);
      if (ref_exp != 0)
        check(ref_ticks - ref_last == ref_exp, "R1/R2/R3/R6 ref interval",
              ref_ticks - ref_last, ref_exp);
      ref_exp  = ref_model(sel_a_i, sel_b_i, plus_one_i);
      ref_last = ref_ticks;
    end
    if (lo_pulse_o) begin
      check(!lo_prev && lo_tick_prev, "R5 lo pulse shape", int'(lo_prev), 0);
      if (lo_exp != 0)
        check(lo_ticks - lo_last == lo_exp, "R4 lo interval", lo_ticks - lo_last, lo_exp);
      lo_exp  = LO_RATIO;
      lo_last = lo_ticks;
    end
    ref_prev = ref_pulse_o;
    lo_prev  = lo_pulse_o;
  endtask

  task automatic drive_en(input bit r, input bit l);
    ref_en_i = r;
    lo_en_i  = l;
    ref_tick_prev = r;
    lo_tick_prev  = l;
    if (r) ref_ticks++;
    if (l) lo_ticks++;
  endtask

  task automatic run(input int n, input int pr, input int pl, input bit wander);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      sample();
      if (wander && ($urandom % 97) == 0) begin
        sel_a_i    = 2'($urandom);
        sel_b_i    = 2'($urandom);
        plus_one_i = 1'($urandom);
        ctrl_mode_i = 2'($urandom);
      end
      drive_en(($urandom % 100) < pr, ($urandom % 100) < pl);
    end
  endtask

  task automatic do_clr();
    @(negedge clk_i);
    sample();
    clr_i = 1'b1;
    drive_en(1'b1, 1'b1);
    @(negedge clk_i);
    sample();
    // R10: pulses cleared
    check(!ref_pulse_o && !lo_pulse_o, "R10 clear", int'(ref_pulse_o | lo_pulse_o), 0);
    clr_i = 1'b0;
    ref_exp = 0;
    lo_exp  = 0;
    drive_en(1'b1, 1'b1);
    @(negedge clk_i);
    // R10: first tick after clear pulses both
    check(ref_pulse_o && lo_pulse_o, "R10 first tick", int'(ref_pulse_o & lo_pulse_o), 1);
    sample();
    drive_en(1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R11: reset state
    check(!ref_pulse_o && !lo_pulse_o && !test_o, "R11 reset outputs",
          int'(ref_pulse_o | lo_pulse_o | test_o), 0);
    rst_ni = 1'b1;
    ctrl_mode_i = 2'b01;
    drive_en(1'b1, 1'b1);
    @(negedge clk_i);
    check(ref_pulse_o && lo_pulse_o, "R11 first tick", int'(ref_pulse_o & lo_pulse_o), 1);
    sample();
    drive_en(1'b0, 1'b0);

    // R1 R2 R3: sweep every code pair with and without increment
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int p = 0; p < 2; p++) begin
          @(negedge clk_i);
          sample();
          sel_a_i = 2'(a);
          sel_b_i = 2'(b);
          plus_one_i = 1'(p);
          ctrl_mode_i = 2'($urandom);
          drive_en(1'b1, 1'b1);
          run(3 * 67, 100, 90, 1'b0);
        end

    do_clr();

    // R6 R7 R8 R9: random mid-period changes and sparse ticks
    for (int s = 0; s < 280; s++) begin
      run(150, 30 + int'($urandom % 71), 85, 1'b1);
      if (($urandom % 25) == 0) do_clr();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule